// File: doc/BRIEF.md
# Serial Port FIFO Pair with Threshold Interrupts

This block holds the data buffering between a register-side host and a serial shift engine. It has one transmit queue, filled by the host and drained by the engine, and one receive queue, filled by the engine and drained by the host. Both queues share the same fixed byte budget. The number of usable entries follows the selected word size, so the same storage holds many short words or a few long ones.

Each queue reports its fill level. Each queue also raises a level-sensitive interrupt. A 2-bit mode picks which fill condition drives that interrupt. The block keeps a sticky receive-overrun flag and a sticky transmit-underrun flag. It packs the levels, the receive-empty indication and both flags into a status word at fixed bit positions, which a register decoder reads. A word-size change or a disable flushes both queues. Bus decoding and the shifter itself sit outside this block.

Top module: `serial_fifo_pair`

## Requirements
- R1: `word_sel` sets the entry capacity. Code 0 gives 8-bit words and 16 entries. Code 1 gives 16-bit words and 8 entries. Codes 2 and 3 give 32-bit words and 4 entries. `tx_full` is high when the transmit level equals the capacity.
- R2: Both queues are first-in first-out. Every word is masked to the selected width, so the bits above the word width read as zero on `rx_rdata` and on `eng_tx_data`.
- R3: `status_word` layout: bit 5 is receive-empty, bit 6 is receive overrun, bit 8 is transmit underrun, bits 20:16 are the transmit level, and bits 28:24 are the receive level. All other bits are zero.
- R4: `irq_ctrl[1:0]` selects the receive interrupt: 0 when the level is zero, 1 when the level is nonzero, 2 when the level is at least half the capacity, 3 when the level equals the capacity.
- R5: `irq_ctrl[3:2]` selects the transmit interrupt: 0 when the level is zero and `eng_busy` is low, 1 when the level is zero, 2 when the free entries are at least half the capacity, 3 when at least one entry is free.
- R6: If `eng_rx_push` arrives while the receive queue is full at the start of that cycle, the overrun flag sets. The incoming word is discarded and the stored words and level are unchanged.
- R7: `eng_tx_req` on an empty transmit queue sets the underrun flag only while `framed` is high.
- R8: `err_clear` clears both sticky flags. If a flag is set and cleared in the same cycle, the set wins.
- R9: Both levels go to zero in the cycle after `enable` is low or `word_sel` differs from its value in the previous cycle. Strobes in those cycles have no effect.
- R10: Levels update on the clock edge after a strobe. A push and a pop on the same queue in one cycle leave that level unchanged.
- R11: A host push to a full transmit queue and a host pop from an empty receive queue are ignored. An engine request on an empty transmit queue does not change its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low flushes both queues |
| word_sel | input | 2 | Word size code |
| irq_ctrl | input | 4 | [1:0] receive interrupt mode, [3:2] transmit interrupt mode |
| framed | input | 1 | Framed operation; enables underrun detection |
| err_clear | input | 1 | Clears the sticky error flags |
| tx_push | input | 1 | Host write strobe into the transmit queue |
| tx_wdata | input | 32 | Host write data |
| rx_pop | input | 1 | Host read strobe from the receive queue |
| rx_rdata | output | 32 | Head of the receive queue, masked |
| eng_tx_req | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 32 | Head of the transmit queue, masked |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_busy | input | 1 | Shifter still holds a word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_level | output | 5 | Transmit fill level |
| rx_level | output | 5 | Receive fill level |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |
| status_word | output | 32 | Packed status |

## Verification
The assertions check several properties on every cycle. Levels must stay within capacity and move by at most one entry per edge. A disable must leave both levels at zero. The empty bit must agree with the receive level. The overrun flag must stay set until cleared, and an overrun must keep the receive level unchanged. The underrun flag must not set outside framed operation. The bench scenarios cover what needs data or mode sweeps: word order and width masking, every interrupt mode at every fill level of a small capacity, the exact status bit layout, the discarded overrun word, and the set-over-clear priority.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  localparam int WORD_W = 32;

  function automatic int word_bytes(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int cap_entries(input logic [1:0] wsel, input int buf_bytes);
    return (buf_bytes + word_bytes(wsel) - 1) / word_bytes(wsel);
  endfunction

  function automatic logic [WORD_W-1:0] mask_word(input logic [1:0] wsel,
                                                  input logic [WORD_W-1:0] d);
    case (wsel)
      2'd0:    return {24'd0, d[7:0]};
      2'd1:    return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic rx_irq_hit(input logic [1:0] mode, input int lvl, input int cap);
    case (mode)
      2'd0:    return lvl == 0;
      2'd1:    return lvl != 0;
      2'd2:    return 2 * lvl >= cap;
      default: return lvl >= cap;
    endcase
  endfunction

  function automatic logic tx_irq_hit(input logic [1:0] mode, input int lvl, input int cap,
                                      input logic busy);
    case (mode)
      2'd0:    return (lvl == 0) && !busy;
      2'd1:    return lvl == 0;
      2'd2:    return 2 * (cap - lvl) >= cap;
      default: return lvl < cap;
    endcase
  endfunction

endpackage

// File: rtl/sfp_ring.sv
module sfp_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_acc,
  output logic          pop_acc
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign full     = level >= cap;
  assign empty    = level == '0;
  assign push_acc = push && !full && !flush;
  assign pop_acc  = pop && !empty && !flush;
  assign rdata    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_acc) begin
        if (int'(wr_ptr) + 1 >= int'(cap)) wr_ptr <= '0;
        else                               wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop_acc) begin
        if (int'(rd_ptr) + 1 >= int'(cap)) rd_ptr <= '0;
        else                               rd_ptr <= rd_ptr + 1'b1;
      end
      case ({push_acc, pop_acc})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/sfp_errs.sv
module sfp_errs (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovr,
  input  logic set_urun,
  input  logic clr,
  output logic ovr,
  output logic urun
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr  <= 1'b0;
      urun <= 1'b0;
    end else begin
      ovr  <= set_ovr  || (ovr  && !clr);
      urun <= set_urun || (urun && !clr);
    end
  end

endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair #(
  parameter int BUF_BYTES = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               enable,
  input  logic [1:0]                         word_sel,
  input  logic [3:0]                         irq_ctrl,
  input  logic                               framed,
  input  logic                               err_clear,
  input  logic                               tx_push,
  input  logic [31:0]                        tx_wdata,
  input  logic                               rx_pop,
  output logic [31:0]                        rx_rdata,
  input  logic                               eng_tx_req,
  output logic [31:0]                        eng_tx_data,
  output logic                               eng_tx_valid,
  input  logic                               eng_busy,
  input  logic                               eng_rx_push,
  input  logic [31:0]                        eng_rx_data,
  output logic                               tx_full,
  output logic [$clog2(BUF_BYTES+1)-1:0]     tx_level,
  output logic [$clog2(BUF_BYTES+1)-1:0]     rx_level,
  output logic                               tx_irq,
  output logic                               rx_irq,
  output logic [31:0]                        status_word
);
  import sfp_pkg::*;

  localparam int LW = $clog2(BUF_BYTES + 1);

  logic [1:0]    word_sel_q;
  logic          flush_evt;
  logic [LW-1:0] cap;
  logic [31:0]   tx_head, rx_head;
  logic          tx_empty, rx_empty, rx_full;
  logic          tx_push_acc, tx_pop_acc, rx_push_acc, rx_pop_acc;
  logic          rx_ovr_evt, tx_urun_evt;
  logic          ovr_flag, urun_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_sel_q <= 2'd0;
    else        word_sel_q <= word_sel;
  end

  assign flush_evt   = !enable || (word_sel != word_sel_q);
  assign cap         = LW'(cap_entries(word_sel, BUF_BYTES));
  assign rx_ovr_evt  = eng_rx_push && rx_full && !flush_evt;
  assign tx_urun_evt = framed && eng_tx_req && tx_empty && !flush_evt;

  sfp_ring #(.DEPTH(BUF_BYTES), .W(32)) u_tx_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_evt),
    .cap      (cap),
    .push     (tx_push),
    .wdata    (mask_word(word_sel, tx_wdata)),
    .pop      (eng_tx_req),
    .rdata    (tx_head),
    .level    (tx_level),
    .full     (tx_full),
    .empty    (tx_empty),
    .push_acc (tx_push_acc),
    .pop_acc  (tx_pop_acc)
  );

  sfp_ring #(.DEPTH(BUF_BYTES), .W(32)) u_rx_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_evt),
    .cap      (cap),
    .push     (eng_rx_push),
    .wdata    (mask_word(word_sel, eng_rx_data)),
    .pop      (rx_pop),
    .rdata    (rx_head),
    .level    (rx_level),
    .full     (rx_full),
    .empty    (rx_empty),
    .push_acc (rx_push_acc),
    .pop_acc  (rx_pop_acc)
  );

  sfp_errs u_errs (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ovr  (rx_ovr_evt),
    .set_urun (tx_urun_evt),
    .clr      (err_clear),
    .ovr      (ovr_flag),
    .urun     (urun_flag)
  );

  assign rx_rdata     = mask_word(word_sel, rx_head);
  assign eng_tx_data  = mask_word(word_sel, tx_head);
  assign eng_tx_valid = !tx_empty;

  assign rx_irq = rx_irq_hit(irq_ctrl[1:0], int'(rx_level), int'(cap));
  assign tx_irq = tx_irq_hit(irq_ctrl[3:2], int'(tx_level), int'(cap), eng_busy);

  always_comb begin
    status_word        = '0;
    status_word[5]     = rx_empty;
    status_word[6]     = ovr_flag;
    status_word[8]     = urun_flag;
    status_word[20:16] = 5'(tx_level);
    status_word[28:24] = 5'(rx_level);
  end

endmodule

// File: rtl/serial_fifo_pair_chk.sv
module serial_fifo_pair_chk #(
  parameter int BUF_BYTES = 16,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [1:0]    word_sel,
  input logic          framed,
  input logic          err_clear,
  input logic          eng_rx_push,
  input logic          rx_pop,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic [31:0]   status_word
);
  import sfp_pkg::*;

  logic [LW-1:0] cap_c;
  assign cap_c = LW'(cap_entries(word_sel, BUF_BYTES));

  // R1: levels never exceed capacity once the word size is settled
  a_r1_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $stable(word_sel)) |-> (tx_level <= cap_c && rx_level <= cap_c));

  // R3: empty bit tracks the receive level
  a_r3_empty_bit: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[5] == (rx_level == '0));

  // R6: overrun keeps contents and raises the flag
  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $stable(word_sel) && eng_rx_push && !rx_pop && rx_level == cap_c)
    |=> (rx_level == $past(rx_level) && status_word[6]));

  // R8: overrun flag is sticky until cleared
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[6] && !err_clear) |=> status_word[6]);

  // R7: underrun never sets outside framed operation
  a_r7_urun_framed: assert property (@(posedge clk) disable iff (!rst_n)
    (!framed && !status_word[8]) |=> !status_word[8]);

  // R9: disable empties both queues
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_level == '0 && rx_level == '0));

  // R10: one entry per edge at most
  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rx_level} <= {1'b0, $past(rx_level)} + 1'b1) &&
    ({1'b0, tx_level} <= {1'b0, $past(tx_level)} + 1'b1));

endmodule

bind serial_fifo_pair serial_fifo_pair_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .word_sel    (word_sel),
  .framed      (framed),
  .err_clear   (err_clear),
  .eng_rx_push (eng_rx_push),
  .rx_pop      (rx_pop),
  .tx_level    (tx_level),
  .rx_level    (rx_level),
  .status_word (status_word)
);

// File: tb/serial_fifo_pair_tb.sv
`timescale 1ns/1ps
module serial_fifo_pair_tb;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic [1:0]  word_sel = 0;
  logic [3:0]  irq_ctrl = 0;
  logic        framed = 0, err_clear = 0;
  logic        tx_push = 0, rx_pop = 0, eng_tx_req = 0, eng_busy = 0, eng_rx_push = 0;
  logic [31:0] tx_wdata = 0, eng_rx_data = 0;
  logic [31:0] rx_rdata, eng_tx_data, status_word;
  logic        eng_tx_valid, tx_full, tx_irq, rx_irq;
  logic [4:0]  tx_level, rx_level;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .word_sel(word_sel), .irq_ctrl(irq_ctrl),
    .framed(framed), .err_clear(err_clear), .tx_push(tx_push), .tx_wdata(tx_wdata),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .eng_tx_req(eng_tx_req), .eng_tx_data(eng_tx_data),
    .eng_tx_valid(eng_tx_valid), .eng_busy(eng_busy), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .tx_full(tx_full), .tx_level(tx_level), .rx_level(rx_level),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .status_word(status_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic host_push(input logic [31:0] d);
    tx_push = 1; tx_wdata = d; tick(); tx_push = 0;
  endtask
  task automatic eng_push(input logic [31:0] d);
    eng_rx_push = 1; eng_rx_data = d; tick(); eng_rx_push = 0;
  endtask
  task automatic host_pop(); rx_pop = 1; tick(); rx_pop = 0; endtask
  task automatic eng_take(); eng_tx_req = 1; tick(); eng_tx_req = 0; endtask
  task automatic set_wsel(input logic [1:0] w); word_sel = w; tick(); tick(); endtask

  task automatic t_reset();
    chk("R3 reset status", status_word, 32'h0000_0020);
    chk("R4 reset rx_irq mode0", {31'd0, rx_irq}, 32'd1);
    chk("R5 reset tx_irq mode0", {31'd0, tx_irq}, 32'd1);
    enable = 1; tick();
  endtask

  task automatic t_capacity();
    set_wsel(2'd0);
    for (int i = 0; i < 17; i++) host_push(32'h10 + i);
    chk("R1 byte capacity 16", {27'd0, tx_level}, 32'd16);
    chk("R1 tx_full", {31'd0, tx_full}, 32'd1);
    chk("R11 head kept after overfill", eng_tx_data, 32'h10);
    set_wsel(2'd1);
    chk("R9 word_sel change flush", {27'd0, tx_level}, 32'd0);
    for (int i = 0; i < 9; i++) host_push(32'h20 + i);
    chk("R1 halfword capacity 8", {27'd0, tx_level}, 32'd8);
    set_wsel(2'd3);
    for (int i = 0; i < 5; i++) host_push(32'h30 + i);
    chk("R1 word capacity 4", {27'd0, tx_level}, 32'd4);
    set_wsel(2'd2);
  endtask

  task automatic t_order_mask();
    set_wsel(2'd1);
    eng_push(32'hDEAD_BEEF); eng_push(32'h1234_5678);
    chk("R2 rx mask halfword", rx_rdata, 32'h0000_BEEF);
    host_pop();
    chk("R2 rx order", rx_rdata, 32'h0000_5678);
    host_pop();
    host_pop();
    chk("R11 pop on empty", {27'd0, rx_level}, 32'd0);
    set_wsel(2'd0);
    host_push(32'hAABB_CCDD);
    chk("R2 tx mask byte", eng_tx_data, 32'h0000_00DD);
    eng_take();
    eng_take();
    chk("R11 req on empty", {27'd0, tx_level}, 32'd0);
    set_wsel(2'd2);
  endtask

  task automatic t_rx_irq();
    for (int l = 0; l <= 4; l++) begin
      for (int m = 0; m < 4; m++) begin
        logic e;
        irq_ctrl = {2'b00, 2'(m)}; #1;
        case (m)
          0: e = (l == 0);
          1: e = (l > 0);
          2: e = (l >= 2);
          default: e = (l == 4);
        endcase
        chk($sformatf("R4 rx mode%0d lvl%0d", m, l), {31'd0, rx_irq}, {31'd0, e});
      end
      if (l < 4) eng_push(32'h100 + l);
    end
    for (int l = 0; l < 4; l++) begin
      chk("R2 rx fifo order", rx_rdata, 32'h100 + l);
      host_pop();
    end
  endtask

  task automatic t_tx_irq();
    for (int l = 0; l <= 4; l++) begin
      for (int b = 0; b < 2; b++) begin
        for (int m = 0; m < 4; m++) begin
          logic e;
          eng_busy = b[0]; irq_ctrl = {2'(m), 2'b00}; #1;
          case (m)
            0: e = (l == 0) && (b == 0);
            1: e = (l == 0);
            2: e = (4 - l) >= 2;
            default: e = (l < 4);
          endcase
          chk($sformatf("R5 tx mode%0d lvl%0d busy%0d", m, l, b), {31'd0, tx_irq}, {31'd0, e});
        end
      end
      eng_busy = 0;
      if (l < 4) host_push(32'h200 + l);
    end
    for (int l = 0; l < 4; l++) begin
      chk("R2 tx fifo order", eng_tx_data, 32'h200 + l);
      eng_take();
    end
  endtask

  task automatic t_status();
    for (int i = 0; i < 3; i++) host_push(i);
    for (int i = 0; i < 2; i++) eng_push(i);
    chk("R3 status layout", status_word, 32'h0203_0000);
    tx_push = 1; tx_wdata = 9; eng_tx_req = 1;
    eng_rx_push = 1; eng_rx_data = 9; rx_pop = 1;
    tick();
    tx_push = 0; eng_tx_req = 0; eng_rx_push = 0; rx_pop = 0;
    chk("R10 tx push+pop level", {27'd0, tx_level}, 32'd3);
    chk("R10 rx push+pop level", {27'd0, rx_level}, 32'd2);
    enable = 0; tick();
    chk("R9 disable flush", {22'd0, tx_level, rx_level}, 32'd0);
    host_push(5); eng_push(5);
    chk("R9 strobes ignored while disabled", {22'd0, tx_level, rx_level}, 32'd0);
    enable = 1; tick();
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 4; i++) eng_push(32'hA0 + i);
    chk("R6 no flag before overrun", {31'd0, status_word[6]}, 32'd0);
    eng_push(32'h99);
    chk("R6 overrun flag", {31'd0, status_word[6]}, 32'd1);
    chk("R6 level kept", {27'd0, rx_level}, 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R6 contents kept", rx_rdata, 32'hA0 + i);
      host_pop();
    end
    chk("R6 extra word discarded", {27'd0, rx_level}, 32'd0);
    err_clear = 1; tick(); err_clear = 0;
    chk("R8 clear", {31'd0, status_word[6]}, 32'd0);
    for (int i = 0; i < 4; i++) eng_push(i);
    eng_rx_push = 1; err_clear = 1; tick(); eng_rx_push = 0; err_clear = 0;
    chk("R8 set wins over clear", {31'd0, status_word[6]}, 32'd1);
    err_clear = 1; tick(); err_clear = 0;
    enable = 0; tick(); enable = 1; tick();
  endtask

  task automatic t_underrun();
    framed = 0; eng_take();
    chk("R7 no underrun unframed", {31'd0, status_word[8]}, 32'd0);
    framed = 1; eng_take(); framed = 0;
    chk("R7 underrun framed", {31'd0, status_word[8]}, 32'd1);
    err_clear = 1; tick(); err_clear = 0;
    chk("R8 clear underrun", {31'd0, status_word[8]}, 32'd0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_capacity();
    t_order_mask();
    t_rx_irq();
    t_tx_irq();
    t_status();
    t_overrun();
    t_underrun();
    done = 1;
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

endmodule